// File: doc/BRIEF.md
# Variable-Length 1-D DCT/IDCT Engine

This block computes a one-dimensional discrete cosine transform (forward) or its inverse over a line of up to eight samples. The number of active samples N, from 0 to 8, is chosen separately for every line. A line always occupies eight consecutive input slots. The active samples are packed into the first N slots, and the remaining slots carry don't-care data. The result leaves as eight consecutive output slots. The first N slots hold the transformed values, with the lowest-frequency term first, and the rest are zero.

Samples arrive serially and are gathered into a parallel word. The word then moves through a fold (add/subtract) stage, a coefficient-index sequencer feeding a bank of multipliers, and an accumulate/round/saturate stage. A small context word holding N, the direction and the coefficient index travels alongside the data. Each stage decodes its own controls from the context that belongs to the data it holds. This lets lines of different length and direction follow one another with no idle slots. The coefficients are orthonormal DCT-II bases for every length, held as signed fixed-point constants computed at elaboration.

Top module: `vl_dct1d`

## Requirements
- R1: After reset, out_valid_o stays low until a complete line has been accepted.
- R2: A line starts on a slot with in_valid_i and in_first_i both high. It consists of that slot and the next seven valid slots. in_len_i and in_inv_i are sampled on the start slot. Coefficient 0 of the line appears on the 4th rising edge after the edge that accepted input slot 7. The line is followed by 7 more valid slots on consecutive cycles. out_first_o is high only with coefficient 0.
- R3: In forward mode (in_inv_i=0) with 1<=N<=8, output k<N is the rounded value of sum over n<N of Q[N][k][n]*x[n]. Here Q[N][k][n] is round-to-nearest(16384 * s_k * cos(pi*(2n+1)*k/(2N))), with s_0=sqrt(1/N) and s_k=sqrt(2/N) for k>0. Rounding of a sum S is (S + 8192) arithmetically shifted right by 14.
- R4: With N=8 the forward output equals the conventional orthonormal 8-point DCT under the same quantization and rounding.
- R5: Input slots at positions N and above have no effect on the result, and output slots at positions N and above are zero.
- R6: In inverse mode (in_inv_i=1), output k<N is the rounded sum over j<N of Q[N][j][k]*X[j], using the transposed coefficient set.
- R7: A line with N=0 yields eight zero outputs. A length above 8 is treated as 8.
- R8: Outputs saturate to the signed OUT_W range, which is [-2048, 2047] by default.
- R9: Lines of different length and direction given back to back produce back-to-back output lines with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input slot valid |
| in_first_i | input | 1 | Input slot is slot 0 of a line |
| in_len_i | input | 4 | Active sample count N, sampled on slot 0 |
| in_inv_i | input | 1 | 1 = inverse transform, sampled on slot 0 |
| in_data_i | input | IN_W | Signed input sample |
| out_valid_o | output | 1 | Output slot valid |
| out_first_o | output | 1 | Output slot carries coefficient 0 |
| out_data_o | output | OUT_W | Signed output value |

## Verification
If a context word slips a stage relative to its data, the wrong row or column of the coefficient set is applied. Length-dependent values then show up on the first line whose length differs from the one before, four cycles after its last input. A wrong fold or a stale held word corrupts every coefficient of the affected line, so one line of checks exposes it. Sequencer overlap or a broken slot count appears as a missing out_first_o, or as an idle gap inside the back-to-back output stream.

// File: rtl/vl_dct_pkg.sv
`timescale 1ns/1ps
package vl_dct_pkg;
  localparam int MAX_N   = 8;
  localparam int HALF_N  = MAX_N / 2;
  localparam int LEN_W   = $clog2(MAX_N + 1);
  localparam int IDX_W   = $clog2(MAX_N);
  localparam int CQ_W    = 16;
  localparam int CQ_FRAC = 14;
  localparam int TAB_N   = (MAX_N + 1) * MAX_N * MAX_N;
  localparam int TIDX_W  = $clog2(TAB_N);
  localparam real PI_R   = 3.14159265358979323846;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             inv;
    logic [IDX_W-1:0] k;
  } ctx_t;

  typedef logic [TAB_N-1:0][CQ_W-1:0] coef_tab_t;

  function automatic real dct_cos(real a);
    real t, s;
    while (a > PI_R) a = a - 2.0 * PI_R;
    t = 1.0;
    s = 1.0;
    for (int i = 1; i < 40; i++) begin
      t = -t * a * a / (real'(2 * i - 1) * real'(2 * i));
      s = s + t;
    end
    return s;
  endfunction

  function automatic real dct_sqrt(real v);
    real r;
    r = 1.0;
    for (int i = 0; i < 60; i++) r = 0.5 * (r + v / r);
    return r;
  endfunction

  // entry [len][row][col], rows and cols at or beyond len stay zero
  function automatic coef_tab_t build_coef_tab();
    coef_tab_t t;
    real c, sc;
    int q;
    t = '0;
    for (int n = 1; n <= MAX_N; n++)
      for (int k = 0; k < n; k++)
        for (int j = 0; j < n; j++) begin
          sc = (k == 0) ? dct_sqrt(1.0 / real'(n)) : dct_sqrt(2.0 / real'(n));
          c  = sc * dct_cos(PI_R * real'((2 * j + 1) * k) / real'(2 * n));
          q  = int'(c * real'(1 << CQ_FRAC));
          t[(n * MAX_N + k) * MAX_N + j] = CQ_W'(q);
        end
    return t;
  endfunction
endpackage

// File: rtl/vl_dct_s2p.sv
`timescale 1ns/1ps
module vl_dct_s2p import vl_dct_pkg::*; #(
  parameter int IN_W = 12
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic                            first_i,
  input  logic [LEN_W-1:0]                len_i,
  input  logic                            inv_i,
  input  logic [IN_W-1:0]                 data_i,
  output logic [MAX_N-1:0][IN_W-1:0]      vec_o,
  output ctx_t                            ctx_o,
  output logic                            done_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             take;
  logic [IDX_W-1:0] slot;
  logic [LEN_W-1:0] len_now, len_clip;

  assign len_clip = (len_i > LEN_W'(MAX_N)) ? LEN_W'(MAX_N) : len_i;
  assign take     = valid_i && (first_i || cnt_q != '0);
  assign slot     = first_i ? '0 : cnt_q[IDX_W-1:0];
  assign len_now  = first_i ? len_clip : ctx_o.len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      vec_o  <= '0;
      ctx_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= take && (slot == IDX_W'(MAX_N - 1));
      if (take) begin
        // padding slots are stored as zero so later stages never see them
        vec_o[slot] <= (LEN_W'(slot) < len_now) ? data_i : '0;
        cnt_q       <= (slot == IDX_W'(MAX_N - 1)) ? '0 : LEN_W'(slot) + LEN_W'(1);
        if (first_i) begin
          ctx_o.len <= len_clip;
          ctx_o.inv <= inv_i;
          ctx_o.k   <= '0;
        end
      end
    end
  end

  a_r2_line_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/vl_dct_addsub.sv
`timescale 1ns/1ps
module vl_dct_addsub import vl_dct_pkg::*; #(
  parameter int IN_W = 12,
  localparam int AW  = IN_W + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [MAX_N-1:0][IN_W-1:0]    vec_i,
  input  ctx_t                          ctx_i,
  input  logic                          v_i,
  output logic [MAX_N-1:0][AW-1:0]      vec_o,
  output ctx_t                          ctx_o,
  output logic                          v_o
);
  logic [MAX_N-1:0][AW-1:0] nx;
  logic [LEN_W-1:0]         half;
  logic [IDX_W-1:0]         m;
  logic signed [AW-1:0]     a_s, b_s;

  assign half = ctx_i.len >> 1;

  // forward: fold into sums [0..HALF-1] and differences [HALF..]; odd centre in sum slot
  always_comb begin
    nx  = '0;
    m   = '0;
    a_s = '0;
    b_s = '0;
    for (int j = 0; j < MAX_N; j++) begin
      if (ctx_i.inv) begin
        nx[j] = {vec_i[j][IN_W-1], vec_i[j]};
      end else if (j < HALF_N) begin
        m   = IDX_W'(ctx_i.len - LEN_W'(1) - LEN_W'(j));
        a_s = $signed({vec_i[j][IN_W-1], vec_i[j]});
        b_s = $signed({vec_i[m][IN_W-1], vec_i[m]});
        if (LEN_W'(j) < half) begin
          nx[j]          = a_s + b_s;
          nx[HALF_N + j] = a_s - b_s;
        end else if (ctx_i.len[0] && LEN_W'(j) == half) begin
          nx[j] = a_s;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_o <= '0;
      ctx_o <= '0;
      v_o   <= 1'b0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        vec_o <= nx;
        ctx_o <= ctx_i;
      end
    end
  end
endmodule

// File: rtl/vl_dct_mul.sv
`timescale 1ns/1ps
module vl_dct_mul import vl_dct_pkg::*; #(
  parameter int IN_W = 12,
  localparam int AW  = IN_W + 1,
  localparam int PW  = AW + CQ_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [MAX_N-1:0][AW-1:0]    vec_i,
  input  ctx_t                        ctx_i,
  input  logic                        v_i,
  output logic [MAX_N-1:0][PW-1:0]    prod_o,
  output ctx_t                        ctx_o,
  output logic                        v_o
);
  localparam coef_tab_t TAB = build_coef_tab();

  logic                     act_q;
  logic [IDX_W-1:0]         k_q;
  logic [MAX_N-1:0][AW-1:0] hold_q;
  ctx_t                     sctx_q;
  logic signed [AW-1:0]     op_a [MAX_N];
  logic signed [CQ_W-1:0]   cf_a [MAX_N];
  logic [TIDX_W-1:0]        idx;

  // serialiser over coefficient index; holds the folded word for a full line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      k_q    <= '0;
      hold_q <= '0;
      sctx_q <= '0;
    end else if (v_i) begin
      act_q  <= 1'b1;
      k_q    <= '0;
      hold_q <= vec_i;
      sctx_q <= ctx_i;
    end else if (act_q) begin
      if (k_q == IDX_W'(MAX_N - 1)) act_q <= 1'b0;
      k_q <= k_q + IDX_W'(1);
    end
  end

  // per-stage decode: operand choice and coefficient orientation
  always_comb begin
    idx = '0;
    for (int j = 0; j < MAX_N; j++) begin
      op_a[j] = '0;
      cf_a[j] = '0;
      if (sctx_q.inv) begin
        idx     = TIDX_W'((int'(sctx_q.len) * MAX_N + j) * MAX_N + int'(k_q));
        op_a[j] = $signed(hold_q[j]);
        cf_a[j] = $signed(TAB[idx]);
      end else if (j < HALF_N) begin
        idx     = TIDX_W'((int'(sctx_q.len) * MAX_N + int'(k_q)) * MAX_N + j);
        op_a[j] = k_q[0] ? $signed(hold_q[HALF_N + j]) : $signed(hold_q[j]);
        cf_a[j] = $signed(TAB[idx]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_o <= '0;
      ctx_o  <= '0;
      v_o    <= 1'b0;
    end else begin
      v_o <= act_q;
      if (act_q) begin
        ctx_o     <= sctx_q;
        ctx_o.k   <= k_q;
        for (int j = 0; j < MAX_N; j++)
          prod_o[j] <= PW'(PW'(op_a[j]) * PW'(cf_a[j]));
      end
    end
  end

  a_r9_seq_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_i |-> (!act_q || k_q == IDX_W'(MAX_N - 1)));
endmodule

// File: rtl/vl_dct_acc.sv
`timescale 1ns/1ps
module vl_dct_acc import vl_dct_pkg::*; #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 12,
  localparam int PW   = IN_W + 1 + CQ_W,
  localparam int SW   = PW + IDX_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [MAX_N-1:0][PW-1:0]    prod_i,
  input  ctx_t                        ctx_i,
  input  logic                        v_i,
  output logic                        valid_o,
  output logic                        first_o,
  output logic [OUT_W-1:0]            data_o
);
  localparam logic signed [SW-1:0] MAXV = {{(SW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
  localparam logic signed [SW-1:0] HALF_LSB = SW'(1) <<< (CQ_FRAC - 1);

  logic signed [SW-1:0] sum, rnd;
  logic [OUT_W-1:0]     res;

  always_comb begin
    sum = '0;
    for (int j = 0; j < MAX_N; j++) sum = sum + SW'($signed(prod_i[j]));
    rnd = (sum + HALF_LSB) >>> CQ_FRAC;
    if ({1'b0, ctx_i.k} >= ctx_i.len) res = '0;
    else if (rnd > MAXV)              res = MAXV[OUT_W-1:0];
    else if (rnd < MINV)              res = MINV[OUT_W-1:0];
    else                              res = rnd[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      first_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= v_i;
      first_o <= v_i && (ctx_i.k == '0);
      data_o  <= v_i ? res : '0;
    end
  end

  a_r2_rise_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> first_o);
  a_r9_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !first_o) |-> $past(valid_o));
endmodule

// File: rtl/vl_dct1d.sv
`timescale 1ns/1ps
module vl_dct1d import vl_dct_pkg::*; #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic               in_first_i,
  input  logic [3:0]         in_len_i,
  input  logic               in_inv_i,
  input  logic [IN_W-1:0]    in_data_i,
  output logic               out_valid_o,
  output logic               out_first_o,
  output logic [OUT_W-1:0]   out_data_o
);
  localparam int AW = IN_W + 1;
  localparam int PW = AW + CQ_W;

  logic [MAX_N-1:0][IN_W-1:0] s2p_vec;
  logic [MAX_N-1:0][AW-1:0]   as_vec;
  logic [MAX_N-1:0][PW-1:0]   mul_prod;
  ctx_t                       s2p_ctx, as_ctx, mul_ctx;
  logic                       s2p_v, as_v, mul_v;

  vl_dct_s2p #(.IN_W(IN_W)) u_s2p (
    .clk_i, .rst_ni, .valid_i(in_valid_i), .first_i(in_first_i),
    .len_i(LEN_W'(in_len_i)), .inv_i(in_inv_i), .data_i(in_data_i),
    .vec_o(s2p_vec), .ctx_o(s2p_ctx), .done_o(s2p_v));

  vl_dct_addsub #(.IN_W(IN_W)) u_addsub (
    .clk_i, .rst_ni, .vec_i(s2p_vec), .ctx_i(s2p_ctx), .v_i(s2p_v),
    .vec_o(as_vec), .ctx_o(as_ctx), .v_o(as_v));

  vl_dct_mul #(.IN_W(IN_W)) u_mul (
    .clk_i, .rst_ni, .vec_i(as_vec), .ctx_i(as_ctx), .v_i(as_v),
    .prod_o(mul_prod), .ctx_o(mul_ctx), .v_o(mul_v));

  vl_dct_acc #(.IN_W(IN_W), .OUT_W(OUT_W)) u_acc (
    .clk_i, .rst_ni, .prod_i(mul_prod), .ctx_i(mul_ctx), .v_i(mul_v),
    .valid_o(out_valid_o), .first_o(out_first_o), .data_o(out_data_o));
endmodule

// File: tb/vl_dct1d_bench.sv
`timescale 1ns/1ps
module vl_dct1d_bench;
  localparam int IW = 12;
  localparam int OW = 12;
  localparam real PI = 3.14159265358979323846;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, in_first_i = 1'b0, in_inv_i = 1'b0;
  logic [3:0] in_len_i = '0;
  logic [IW-1:0] in_data_i = '0;
  logic out_valid_o, out_first_o;
  logic [OW-1:0] out_data_o;

  vl_dct1d #(.IN_W(IW), .OUT_W(OW)) u_vl_dct1d (.*);

  always #2.5 clk_i = ~clk_i;

  int cyc = 0, n_chk = 0, n_fail = 0, last_c = 0;
  int xin[8];
  int got_v[$], got_c[$], exp_v[$];
  bit got_f[$], exp_f[$];

  always @(posedge clk_i) cyc <= cyc + 1;
  always @(negedge clk_i)
    if (rst_ni && out_valid_o) begin
      got_v.push_back(int'($signed(out_data_o)));
      got_f.push_back(out_first_o);
      got_c.push_back(cyc);
    end

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int coefq(int n, int k, int j);
    real c;
    c = ((k == 0) ? $sqrt(1.0 / n) : $sqrt(2.0 / n)) * $cos(PI * (2 * j + 1) * k / (2.0 * n));
    return int'(c * 16384.0);
  endfunction

  task automatic send_line(int ln, bit inv);
    int le;
    longint acc, r;
    le = (ln > 8) ? 8 : ln;
    for (int k = 0; k < 8; k++) begin
      acc = 0;
      for (int n = 0; n < le; n++)
        acc += longint'(inv ? coefq(le, n, k) : coefq(le, k, n)) * xin[n];
      r = (acc + 8192) >>> 14;
      if (r > 2047) r = 2047;
      if (r < -2048) r = -2048;
      exp_v.push_back(k < le ? int'(r) : 0);
      exp_f.push_back(k == 0);
    end
    for (int s = 0; s < 8; s++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1;
      in_first_i = (s == 0);
      in_len_i   = s == 0 ? 4'(ln) : 4'(0);
      in_inv_i   = s == 0 ? inv : 1'b0;
      in_data_i  = IW'(xin[s]);
      if (s == 7) last_c = cyc;
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_first_i = 1'b0;
  endtask

  task automatic collect(string req);
    int sz;
    repeat (40) begin
      if (got_v.size() >= exp_v.size()) break;
      @(negedge clk_i);
    end
    repeat (2) @(negedge clk_i);
    chk({req, " count"}, got_v.size(), exp_v.size());
    sz = (got_v.size() < exp_v.size()) ? got_v.size() : exp_v.size();
    for (int i = 0; i < sz; i++) begin
      chk(req, got_v[i], exp_v[i]);
      chk({req, " R2 first"}, int'(got_f[i]), int'(exp_f[i]));
    end
    got_v.delete(); got_f.delete(); got_c.delete(); exp_v.delete(); exp_f.delete();
  endtask

  task automatic fill(int a, int b, int c, int d, int e, int f, int g, int h);
    xin = '{a, b, c, d, e, f, g, h};
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk_i);
    chk("R1 valid", int'(out_valid_o), 0);
    chk("R1 no output", got_v.size(), 0);
  endtask

  task automatic t_latency_dc8();
    fill(100, 100, 100, 100, 100, 100, 100, 100);
    send_line(8, 1'b0);
    idle();
    repeat (8) @(negedge clk_i);
    chk("R2 latency", (got_c.size() > 0) ? got_c[0] - last_c : -1, 5);
    collect("R4 constant");
    fill(-50, 20, 300, -700, 5, 1000, -1, 64);
    send_line(8, 1'b0);
    idle();
    collect("R4 mixed");
  endtask

  task automatic t_var_len();
    fill(10, -200, 333, 0, 0, 0, 0, 0);
    send_line(3, 1'b0); idle(); collect("R3 n3");
    fill(500, 400, -300, 200, -100, 0, 0, 0);
    send_line(5, 1'b0); idle(); collect("R3 n5");
    fill(1, 2, 3, 4, 5, 6, 7, 0);
    send_line(7, 1'b0); idle(); collect("R3 n7");
    fill(-900, 0, 0, 0, 0, 0, 0, 0);
    send_line(1, 1'b0); idle(); collect("R3 n1");
  endtask

  task automatic t_padding();
    fill(120, -80, 60, 40, 2047, -2048, 1234, -999);
    send_line(4, 1'b0); idle(); collect("R5 fwd pad");
    fill(300, 50, -20, 2047, 2047, 2047, 2047, 2047);
    send_line(3, 1'b1); idle(); collect("R5 inv pad");
  endtask

  task automatic t_inverse();
    fill(800, -100, 50, 0, 30, -7, 0, 0);
    send_line(6, 1'b1); idle(); collect("R6 n6");
    fill(400, 200, -150, 90, -60, 30, -10, 5);
    send_line(8, 1'b1); idle(); collect("R6 n8");
  endtask

  task automatic t_zero_clamp();
    fill(700, 700, 700, 700, 700, 700, 700, 700);
    send_line(0, 1'b0); idle(); collect("R7 n0");
    fill(9, -18, 27, -36, 45, -54, 63, -72);
    send_line(12, 1'b0); idle(); collect("R7 clamp");
  endtask

  task automatic t_saturate();
    fill(2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047);
    send_line(8, 1'b0); idle(); collect("R8 pos");
    fill(-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048);
    send_line(8, 1'b0); idle(); collect("R8 neg");
    fill(2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047);
    send_line(8, 1'b1); idle(); collect("R8 inv");
  endtask

  task automatic t_back_to_back();
    int ok;
    fill(11, 22, 33, 44, 55, 66, 77, 88);        send_line(8, 1'b0);
    fill(-1500, 0, 0, 0, 0, 0, 0, 0);           send_line(1, 1'b0);
    fill(600, -300, 150, -75, 30, 0, 0, 0);     send_line(5, 1'b1);
    fill(250, -250, 0, 0, 0, 0, 0, 0);          send_line(2, 1'b0);
    fill(5, 5, 5, 5, 5, 5, 5, 5);               send_line(0, 1'b1);
    idle();
    repeat (12) @(negedge clk_i);
    ok = 1;
    for (int i = 1; i < got_c.size(); i++)
      if (got_c[i] != got_c[0] + i) ok = 0;
    chk("R9 continuous", ok, 1);
    collect("R9 mixed");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_latency_dc8();
    t_var_len();
    t_padding();
    t_inverse();
    t_zero_clamp();
    t_saturate();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule